// File: doc/BRIEF.md
# Sequential Five-Step Integer Processor

This block is a compact 32-bit integer processor that runs one instruction at a time. Every instruction walks through a fixed sequence of register-transfer steps: fetch, decode with operand read, execute or address computation, memory access or branch completion, and result write-back. Instructions that have no use for a step skip it, so an instruction takes between two and five clock cycles. Between steps the state lives in a small set of holding registers: the instruction word, the sequential next PC, the two operands, the extended immediate, the execute result and the loaded data.

The core has a 32-entry general register file, word loads and stores, register-register and register-immediate arithmetic and logic, zero-test conditional branches and PC-relative jumps with an optional link. It talks to an instruction memory and a data memory. Both memories answer a read in the same cycle as the address, and the data memory takes a write on the clock edge that ends the cycle in which the write strobe is high. Instruction bits are numbered big-endian: bit 0 is the most significant bit of the word.

Top module: `lsc_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC is loaded with RESET_PC (default 0) and no data write is pending. In the cycle after that edge, `imem_en` is 1, `imem_addr` equals RESET_PC and `dmem_we` is 0.
- R2: Instruction fields use big-endian numbering, so bit 0 is the MSB. The opcode is in bits 0–5 and the first source register is in bits 6–10. Bits 11–15 hold the I-type destination, which is also the store data register, or the R-type second source. An R-type destination is in bits 16–20 and its function code is in bits 26–31.
- R3: The I-type immediate is in bits 16–31 and is sign-extended from bit 16.
- R4: R-type instructions (opcode 0x00) take function codes 0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR and 5 SLT. SLT gives 1 when rs1 is less than rs2 as signed values and 0 otherwise.
- R5: Immediate ALU opcodes are 0x08 ADDI, 0x09 SUBI, 0x0A ANDI, 0x0B ORI, 0x0C XORI and 0x0D SLTI. Each combines rs1 with the extended immediate and writes the register in bits 11–15.
- R6: LW (opcode 0x23) loads the word at rs1 + immediate into the register in bits 11–15 and takes 5 cycles.
- R7: SW (opcode 0x2B) takes 4 cycles. It raises `dmem_we` for exactly one cycle, during which `dmem_addr` is rs1 + immediate and `dmem_wdata` is the register in bits 11–15. `dmem_we` is never high in a fetch cycle.
- R8: BEQZ (opcode 0x04) branches when rs1 is zero and BNEZ (opcode 0x05) branches when rs1 is non-zero. A taken branch goes to the next sequential PC + immediate and a branch not taken goes to the next sequential PC. Both take 4 cycles.
- R9: J (opcode 0x02) and JAL (opcode 0x03) go to the next sequential PC + the sign-extended 26-bit offset in bits 6–31. JAL also writes the next sequential PC into register 31. J takes 4 cycles and JAL takes 5.
- R10: Register 0 always reads as zero. Writes to register 0 have no effect.
- R11: Register-register and register-immediate ALU instructions take 4 cycles. The instruction address advances by 4 on the cycle after every fetch.
- R12: An opcode not listed here, or an R-type function code above 5, is a no-op. It changes no register and no memory, and the next fetch comes 2 cycles after its own fetch.
- R13: `imem_en` is high for exactly one cycle per instruction, and `imem_addr` is word-aligned whenever it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_en | output | 1 | Fetch strobe, one cycle per instruction |
| imem_addr | output | XLEN | Instruction address (the PC) |
| imem_rdata | input | 32 | Instruction word, same-cycle read |
| dmem_addr | output | XLEN | Data address for load or store |
| dmem_wdata | output | XLEN | Store data |
| dmem_we | output | 1 | Data write strobe |
| dmem_rdata | input | XLEN | Load data, same-cycle read |

## Verification
The assertions take for granted that both memories return data in the same cycle as the address. They also assume every branch immediate and jump offset is a multiple of four, which keeps the fetch address word-aligned. The bench program uses only offsets of ±4 and +8, and it models both memories as combinational reads indexed by word address, with data writes on the clock edge. The instructions a taken branch or jump skips are stores to an address that is otherwise never written, so any wrongly executed skipped instruction shows up at the data port as an unexpected write.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  typedef enum logic [2:0] {
    S_FETCH,
    S_DECODE,
    S_EXEC,
    S_MEM,
    S_WB
  } state_e;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SLT = 3'd5
  } alu_op_e;

  typedef enum logic [2:0] {
    K_NOP,
    K_RALU,
    K_IALU,
    K_LOAD,
    K_STORE,
    K_BRANCH,
    K_JUMP
  } kind_e;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_J    = 6'h02;
  localparam logic [5:0] OPC_JAL  = 6'h03;
  localparam logic [5:0] OPC_BEQZ = 6'h04;
  localparam logic [5:0] OPC_BNEZ = 6'h05;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_SUBI = 6'h09;
  localparam logic [5:0] OPC_ANDI = 6'h0A;
  localparam logic [5:0] OPC_ORI  = 6'h0B;
  localparam logic [5:0] OPC_XORI = 6'h0C;
  localparam logic [5:0] OPC_SLTI = 6'h0D;
  localparam logic [5:0] OPC_LW   = 6'h23;
  localparam logic [5:0] OPC_SW   = 6'h2B;

  localparam int unsigned FUNC_MAX = 5;

  typedef struct packed {
    kind_e      kind;
    alu_op_e    op;
    logic       on_nonzero;
    logic       link;
    logic [4:0] src1;
    logic [4:0] src2;
    logic [4:0] dst;
  } dec_t;

endpackage

// File: rtl/lsc_decode.sv
module lsc_decode
  import lsc_pkg::*;
#(
  parameter int unsigned LINK_REG = 31
) (
  input  logic [31:0] ir,
  output dec_t        dec
);

  logic unused_bits;
  assign unused_bits = ^ir[10:6];

  always_comb begin
    dec            = '0;
    dec.kind       = K_NOP;
    dec.op         = OP_ADD;
    dec.src1       = ir[25:21];
    dec.src2       = ir[20:16];
    dec.dst        = ir[20:16];
    case (ir[31:26])
      OPC_REG: begin
        if (ir[5:0] <= 6'(FUNC_MAX)) begin
          dec.kind = K_RALU;
          dec.op   = alu_op_e'(ir[2:0]);
          dec.dst  = ir[15:11];
        end
      end
      OPC_ADDI, OPC_SUBI, OPC_ANDI, OPC_ORI, OPC_XORI, OPC_SLTI: begin
        dec.kind = K_IALU;
        dec.op   = alu_op_e'(ir[28:26]);
      end
      OPC_LW:  dec.kind = K_LOAD;
      OPC_SW:  dec.kind = K_STORE;
      OPC_BEQZ, OPC_BNEZ: begin
        dec.kind       = K_BRANCH;
        dec.on_nonzero = ir[26];
      end
      OPC_J, OPC_JAL: begin
        dec.kind = K_JUMP;
        dec.link = ir[26];
        dec.dst  = 5'(LINK_REG);
      end
      default: dec.kind = K_NOP;
    endcase
  end

endmodule

// File: rtl/lsc_regfile.sv
module lsc_regfile #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned NRD   = 2,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rd_en,
  input  logic [NRD-1:0][AW-1:0]  rd_addr,
  output logic [NRD-1:0][W-1:0]   rd_data,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [W-1:0]            wr_data
);

  // One storage copy per read port so each maps to a simple dual-port RAM.
  for (genvar p = 0; p < NRD; p++) begin : g_port
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      if (rd_en) q <= (rd_addr[p] == '0) ? '0 : mem[rd_addr[p]];
    end

    assign rd_data[p] = q;
  end

endmodule

// File: rtl/lsc_alu.sv
module lsc_alu
  import lsc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SLT:  y = W'($signed(a) < $signed(b));
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/lsc_core.sv
module lsc_core
  import lsc_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter int unsigned NREGS    = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic            imem_en,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int unsigned IMM_W  = 16;
  localparam int unsigned OFF_W  = 26;
  localparam int unsigned RF_AW  = $clog2(NREGS);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  state_e          state, state_n;
  logic [XLEN-1:0] pc, npc, imm, aluout, lmd;
  logic [31:0]     ir;
  logic            cond;
  logic            fetch_q, we_q;
  dec_t            dec;

  logic [1:0][RF_AW-1:0] rf_raddr;
  logic [1:0][XLEN-1:0]  rf_rdata;
  logic                  rf_we;
  logic [XLEN-1:0]       rf_wdata;
  logic [XLEN-1:0]       a_q, b_q;

  logic [XLEN-1:0] alu_a, alu_b, alu_y, joff;
  alu_op_e         alu_op;

  lsc_decode #(.LINK_REG(NREGS - 1)) u_dec (
    .ir  (ir),
    .dec (dec)
  );

  assign rf_raddr = {RF_AW'(dec.src2), RF_AW'(dec.src1)};
  assign a_q      = rf_rdata[0];
  assign b_q      = rf_rdata[1];
  assign rf_we    = (state == S_WB);

  always_comb begin
    if (dec.kind == K_LOAD)                      rf_wdata = lmd;
    else if (dec.kind == K_JUMP && dec.link)     rf_wdata = npc;
    else                                         rf_wdata = aluout;
  end

  lsc_regfile #(.W(XLEN), .DEPTH(NREGS), .NRD(2)) u_rf (
    .clk     (clk),
    .rd_en   (state == S_DECODE),
    .rd_addr (rf_raddr),
    .rd_data (rf_rdata),
    .wr_en   (rf_we),
    .wr_addr (RF_AW'(dec.dst)),
    .wr_data (rf_wdata)
  );

  assign joff = {{(XLEN-OFF_W){ir[OFF_W-1]}}, ir[OFF_W-1:0]};

  // One adder/ALU serves arithmetic, effective addresses and targets.
  always_comb begin
    alu_a  = a_q;
    alu_b  = imm;
    alu_op = OP_ADD;
    case (dec.kind)
      K_RALU: begin
        alu_b  = b_q;
        alu_op = dec.op;
      end
      K_IALU:   alu_op = dec.op;
      K_BRANCH: alu_a  = npc;
      K_JUMP: begin
        alu_a = npc;
        alu_b = joff;
      end
      default: ;
    endcase
  end

  lsc_alu #(.W(XLEN)) u_alu (
    .a  (alu_a),
    .b  (alu_b),
    .op (alu_op),
    .y  (alu_y)
  );

  always_comb begin
    state_n = state;
    case (state)
      S_FETCH:  state_n = S_DECODE;
      S_DECODE: state_n = (dec.kind == K_NOP) ? S_FETCH : S_EXEC;
      S_EXEC:   state_n = (dec.kind == K_RALU || dec.kind == K_IALU) ? S_WB : S_MEM;
      S_MEM:    state_n = (dec.kind == K_LOAD || (dec.kind == K_JUMP && dec.link))
                          ? S_WB : S_FETCH;
      S_WB:     state_n = S_FETCH;
      default:  state_n = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_FETCH;
      pc      <= RESET_PC;
      npc     <= '0;
      ir      <= '0;
      imm     <= '0;
      aluout  <= '0;
      lmd     <= '0;
      cond    <= 1'b0;
      fetch_q <= 1'b1;
      we_q    <= 1'b0;
    end else begin
      state   <= state_n;
      fetch_q <= (state_n == S_FETCH);
      we_q    <= (state == S_EXEC) && (dec.kind == K_STORE);
      case (state)
        S_FETCH: begin
          ir  <= imem_rdata;
          npc <= pc + STEP;
          pc  <= pc + STEP;
        end
        S_DECODE: imm <= {{(XLEN-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};
        S_EXEC: begin
          aluout <= alu_y;
          cond   <= dec.on_nonzero ? (a_q != '0) : (a_q == '0);
        end
        S_MEM: begin
          if (dec.kind == K_LOAD) lmd <= dmem_rdata;
          if (dec.kind == K_JUMP || (dec.kind == K_BRANCH && cond)) pc <= aluout;
        end
        default: ;
      endcase
    end
  end

  assign imem_en    = fetch_q;
  assign imem_addr  = pc;
  assign dmem_addr  = aluout;
  assign dmem_wdata = b_q;
  assign dmem_we    = we_q;

endmodule

// File: rtl/lsc_core_chk.sv
module lsc_core_chk
  import lsc_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input logic            clk,
  input logic            rst,
  input logic            imem_en,
  input logic [XLEN-1:0] imem_addr,
  input logic            dmem_we
);

  AST_RESET_FETCH: assert property (@(posedge clk)
    rst |=> (imem_en && imem_addr == RESET_PC && !dmem_we)); // R1

  AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    imem_en |=> !imem_en); // R13

  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    imem_en |-> (imem_addr[1:0] == 2'b00)); // R13

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    imem_en |=> (imem_addr == $past(imem_addr) + XLEN'(4))); // R11

  AST_STORE_PULSE: assert property (@(posedge clk) disable iff (rst)
    dmem_we |=> !dmem_we); // R7

  AST_STORE_NOT_FETCH: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && imem_en)); // R7

endmodule

bind lsc_core lsc_core_chk #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .imem_en   (imem_en),
  .imem_addr (imem_addr),
  .dmem_we   (dmem_we)
);

// File: tb/lsc_core_bench.sv
module lsc_core_bench;
  import lsc_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_en, dmem_we;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;

  always #10 clk = ~clk;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  lsc_core u_lsc_core (
    .clk        (clk),
    .rst        (rst),
    .imem_en    (imem_en),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    string       tag;
  } exp_t;

  exp_t fetch_q[$];
  exp_t store_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;
  int   since  = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int func, int rs1, int rs2, int rd);
    return {OPC_REG, 5'(rs1), 5'(rs2), 5'(rd), 5'd0, 6'(func)};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs1, int rd, int imm);
    return {op, 5'(rs1), 5'(rd), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(logic [5:0] op, int off);
    return {op, 26'(off)};
  endfunction

  task automatic push_fetch(int idx, int len, string tag);
    exp_t e;
    e.a = 32'(idx * 4); e.d = 32'(len); e.tag = tag;
    fetch_q.push_back(e);
  endtask
  task automatic push_store(logic [31:0] a, logic [31:0] d, string tag);
    exp_t e;
    e.a = a; e.d = d; e.tag = tag;
    store_q.push_back(e);
  endtask

  // Monitor: compares fetch order, instruction lengths and data writes.
  always @(negedge clk) begin
    if (!rst && !done) begin
      since = since + 1;
      if (imem_en) begin
        if (fetch_q.size() == 0) begin
          done = 1'b1;
        end else begin
          exp_t e;
          e = fetch_q.pop_front();
          check(imem_addr == e.a, e.tag, "fetch address", imem_addr, e.a);
          if (e.d != 0) check(since == int'(e.d), e.tag, "instruction cycles", 32'(since), e.d);
        end
        since = 0;
      end
      if (dmem_we) begin
        if (store_q.size() == 0) begin
          check(1'b0, "R8", "unexpected store addr", dmem_addr, 32'hFFFFFFFF);
        end else begin
          exp_t s;
          s = store_q.pop_front();
          check(dmem_addr == s.a, s.tag, "store address", dmem_addr, s.a);
          check(dmem_wdata == s.d, s.tag, "store data", dmem_wdata, s.d);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'hFC00_0000;
      dmem[i] = 32'h0;
    end
    imem[0]  = enc_i(OPC_ADDI, 0, 1, 5);
    imem[1]  = enc_i(OPC_ADDI, 0, 2, -3);
    imem[2]  = enc_r(0, 1, 2, 3);
    imem[3]  = enc_r(1, 1, 2, 4);
    imem[4]  = enc_r(2, 1, 2, 5);
    imem[5]  = enc_r(3, 1, 2, 6);
    imem[6]  = enc_r(4, 1, 2, 7);
    imem[7]  = enc_r(5, 2, 1, 8);
    imem[8]  = enc_i(OPC_SW, 0, 3, 0);
    imem[9]  = enc_i(OPC_SW, 0, 4, 4);
    imem[10] = enc_i(OPC_SW, 0, 5, 8);
    imem[11] = enc_i(OPC_SW, 0, 6, 12);
    imem[12] = enc_i(OPC_SW, 0, 7, 16);
    imem[13] = enc_i(OPC_SW, 0, 8, 20);
    imem[14] = enc_i(OPC_ADDI, 0, 0, 7);
    imem[15] = enc_i(OPC_SW, 0, 0, 24);
    imem[16] = enc_i(OPC_LW, 0, 9, 4);
    imem[17] = enc_i(OPC_XORI, 9, 10, 16'h00FF);
    imem[18] = enc_i(OPC_SW, 0, 10, 28);
    imem[19] = enc_i(OPC_SW, 0, 9, 32);
    imem[20] = enc_i(OPC_BEQZ, 1, 0, 8);
    imem[21] = enc_i(OPC_BNEZ, 1, 0, 4);
    imem[22] = enc_i(OPC_SW, 0, 1, 60);
    imem[23] = enc_i(OPC_BEQZ, 0, 0, 4);
    imem[24] = enc_i(OPC_SW, 0, 1, 60);
    imem[25] = enc_j(OPC_JAL, 8);
    imem[26] = enc_i(OPC_SW, 0, 1, 60);
    imem[27] = enc_i(OPC_SW, 0, 1, 60);
    imem[28] = enc_i(OPC_SW, 0, 31, 40);
    imem[29] = 32'hFC00_0000;
    imem[30] = enc_j(OPC_J, -4);

    // Expected fetch sequence with the length of the preceding instruction.
    push_fetch(0, 0, "R13");
    push_fetch(1, 4, "R3");
    for (int i = 2; i <= 8; i++) push_fetch(i, 4, "R11");
    for (int i = 9; i <= 16; i++) push_fetch(i, 4, "R7");
    push_fetch(17, 5, "R6");
    push_fetch(18, 4, "R5");
    push_fetch(19, 4, "R7");
    push_fetch(20, 4, "R7");
    push_fetch(21, 4, "R8");   // BEQZ on non-zero: falls through
    push_fetch(23, 4, "R8");   // BNEZ on non-zero: taken
    push_fetch(25, 4, "R8");   // BEQZ on r0: taken
    push_fetch(28, 5, "R9");   // JAL
    push_fetch(29, 4, "R7");
    push_fetch(30, 2, "R12");  // undefined opcode
    push_fetch(30, 4, "R9");   // J to itself
    push_fetch(30, 4, "R9");

    push_store(32'd0,  32'd2,        "R2");
    push_store(32'd4,  32'd8,        "R4");
    push_store(32'd8,  32'd5,        "R4");
    push_store(32'd12, 32'hFFFFFFFD, "R3");
    push_store(32'd16, 32'hFFFFFFF8, "R4");
    push_store(32'd20, 32'd1,        "R4");
    push_store(32'd24, 32'd0,        "R10");
    push_store(32'd28, 32'h000000F7, "R5");
    push_store(32'd32, 32'd8,        "R6");
    push_store(32'd40, 32'd104,      "R9");

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(imem_en == 1'b1, "R1", "reset fetch strobe", 32'(imem_en), 32'd1);
    check(imem_addr == 32'd0, "R1", "reset address", imem_addr, 32'd0);
    check(dmem_we == 1'b0, "R1", "reset write strobe", 32'(dmem_we), 32'd0);
    @(posedge clk);
    #1 rst = 1'b0;

    for (int k = 0; k < 5000 && !done; k++) @(posedge clk);
    if (!done) check(1'b0, "R13", "watchdog expired, fetches left", 32'(fetch_q.size()), 32'd0);
    check(store_q.size() == 0, "R7", "stores not seen", 32'(store_q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule